// File: doc/BRIEF.md
# Serial Word Blink Reporter

This block shows a captured word on one LED as a pulse train that a person can read by eye, for example to recover a fault address from a board that has no other output. A load strobe captures the word together with the timing settings. From then on the block sends the word one bit at a time and repeats it until reset.

Every bit starts with a short dark gap. A lit pulse follows whose length gives the bit's value: one time unit for a zero, three units for a one. After the last bit the LED stays dark for a long pause, and then the word starts again from its most significant bit. The time unit comes from a two-stage prescaler. The first stage counts clock cycles per sub-tick and the second counts sub-ticks per unit. A typical setting is 1000 sub-ticks of 100 µs each, which gives a 100 ms unit.

Top module: `blink_word_reporter`

## Requirements
- R1: After reset and before any accepted load, `led_o` stays at its dark level on every cycle, whatever the values on `word_i`, `sub_div_i` and `unit_len_i`.
- R2: A load while idle captures `word_i`. The pulse train then starts on the clock edge that follows the edge sampling `load_i`, and it begins with the dark gap of bit 31.
- R3: Bits go out from bit 31 down to bit 0. Each bit is dark for one unit, then lit for one unit when the bit is 0 or for three units when it is 1. The LED goes dark again at the end of every lit pulse.
- R4: After bit 0 the LED stays dark for ten units. The sequence then restarts at bit 31 and repeats without end.
- R5: One unit is max(`sub_div_i`,1) × max(`unit_len_i`,1) clock cycles, so a setting of zero counts as one.
- R6: `sub_div_i` and `unit_len_i` are sampled only when a load is accepted. Changing them later leaves the timing of the current display unchanged.
- R7: A load strobe while a word is on display is ignored: the displayed word and its timing do not change.
- R8: With `ACTIVE_LOW`=0 the LED is lit when `led_o`=1 and dark when `led_o`=0. With `ACTIVE_LOW`=1 both levels are inverted.
- R9: Pulling `rst_ni` low forces `led_o` to the dark level at once and returns the block to idle, and the next load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe, captures word and timing when idle |
| word_i | input | WORD_W | Word to display |
| sub_div_i | input | DIV_W | Clock cycles per sub-tick (0 counts as 1) |
| unit_len_i | input | LEN_W | Sub-ticks per time unit (0 counts as 1) |
| led_o | output | 1 | LED drive, polarity set by ACTIVE_LOW |

## Verification
The bench rebuilds the whole lit/dark waveform arithmetically, cycle by cycle, from the word and the unit length, and compares it with the output over whole frames. A bit-order or pulse-length error moves every later edge, and a wrong pause length shows up when the second frame starts early or late. The bench sweeps the divider and the sub-tick count to catch a prescaler that is off by one or multiplies wrongly. It covers settings of zero, which a faulty design would treat as 2^N and so stall the display. It also sends a load strobe and changes the settings during a display: a design that accepted either would change its timing or word in the middle of a frame. Finally, a reset in the middle of a lit pulse must darken the LED at once and re-arm the block.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_MARK  = 2'd2,
    ST_PAUSE = 2'd3
  } blink_state_e;

  localparam int UNIT_CNT_W = 4;
  localparam logic [UNIT_CNT_W-1:0] GAP_UNITS   = 4'd1;
  localparam logic [UNIT_CNT_W-1:0] ZERO_UNITS  = 4'd1;
  localparam logic [UNIT_CNT_W-1:0] ONE_UNITS   = 4'd3;
  localparam logic [UNIT_CNT_W-1:0] PAUSE_UNITS = 4'd10;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
  parameter int DIV_W = 16,
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sub_tick_o,
  output logic             unit_tick_o
);
  logic [DIV_W-1:0] cyc_q, div_last;
  logic [LEN_W-1:0] sub_q, len_last;
  logic             last_cyc, last_sub;

  // zero setting behaves as one
  assign div_last = (div_i == '0) ? '0 : div_i - 1'b1;
  assign len_last = (len_i == '0) ? '0 : len_i - 1'b1;
  assign last_cyc = (cyc_q == div_last);
  assign last_sub = (sub_q == len_last);

  assign sub_tick_o  = run_i && !clear_i && last_cyc;
  assign unit_tick_o = sub_tick_o && last_sub;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      sub_q <= '0;
    end else if (clear_i || !run_i) begin
      cyc_q <= '0;
      sub_q <= '0;
    end else if (last_cyc) begin
      cyc_q <= '0;
      sub_q <= last_sub ? '0 : sub_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
  import blink_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic                  unit_tick_i,
  output logic                  start_o,
  output logic                  mark_o,
  output blink_state_e          state_o,
  output logic [WORD_W-1:0]     word_o,
  output logic [IDX_W-1:0]      bit_idx_o,
  output logic [UNIT_CNT_W-1:0] units_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  blink_state_e          state_q;
  logic [WORD_W-1:0]     word_q;
  logic [IDX_W-1:0]      idx_q;
  logic [UNIT_CNT_W-1:0] units_q;
  logic                  bit_val;

  assign start_o   = load_i && (state_q == ST_IDLE);
  assign bit_val   = word_q[idx_q];
  assign mark_o    = (state_q == ST_MARK);
  assign state_o   = state_q;
  assign word_o    = word_q;
  assign bit_idx_o = idx_q;
  assign units_o   = units_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      idx_q   <= '0;
      units_q <= '0;
    end else if (start_o) begin
      word_q  <= word_i;
      idx_q   <= LAST_IDX;
      units_q <= GAP_UNITS;
      state_q <= ST_GAP;
    end else if (unit_tick_i && state_q != ST_IDLE) begin
      if (units_q > 1) begin
        units_q <= units_q - 1'b1;
      end else begin
        unique case (state_q)
          ST_GAP: begin
            state_q <= ST_MARK;
            units_q <= bit_val ? ONE_UNITS : ZERO_UNITS;
          end
          ST_MARK: begin
            if (idx_q == '0) begin
              state_q <= ST_PAUSE;
              units_q <= PAUSE_UNITS;
            end else begin
              state_q <= ST_GAP;
              idx_q   <= idx_q - 1'b1;
              units_q <= GAP_UNITS;
            end
          end
          ST_PAUSE: begin
            state_q <= ST_GAP;
            idx_q   <= LAST_IDX;
            units_q <= GAP_UNITS;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/blink_led_drive.sv
module blink_led_drive #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic led_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) led_o <= ACTIVE_LOW;
    else         led_o <= mark_i ^ ACTIVE_LOW;
  end
endmodule

// File: rtl/blink_word_reporter.sv
module blink_word_reporter
  import blink_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int DIV_W      = 16,
  parameter int LEN_W      = 12,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DIV_W-1:0]  sub_div_i,
  input  logic [LEN_W-1:0]  unit_len_i,
  output logic              led_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic                  start, mark, sub_tick, unit_tick, running;
  blink_state_e          seq_state;
  logic [WORD_W-1:0]     shown_word;
  logic [IDX_W-1:0]      bit_idx;
  logic [UNIT_CNT_W-1:0] units_left;
  logic [DIV_W-1:0]      div_q;
  logic [LEN_W-1:0]      len_q;

  // timing frozen at load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      len_q <= '0;
    end else if (start) begin
      div_q <= sub_div_i;
      len_q <= unit_len_i;
    end
  end

  assign running = (seq_state != ST_IDLE);

  blink_prescaler #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start),
    .run_i      (running),
    .div_i      (div_q),
    .len_i      (len_q),
    .sub_tick_o (sub_tick),
    .unit_tick_o(unit_tick)
  );

  blink_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .word_i     (word_i),
    .unit_tick_i(unit_tick),
    .start_o    (start),
    .mark_o     (mark),
    .state_o    (seq_state),
    .word_o     (shown_word),
    .bit_idx_o  (bit_idx),
    .units_o    (units_left)
  );

  blink_led_drive #(.ACTIVE_LOW(ACTIVE_LOW)) u_led (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mark_i(mark),
    .led_o (led_o)
  );
endmodule

// File: rtl/blink_word_reporter_chk.sv
module blink_word_reporter_chk
  import blink_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int IDX_W     = $clog2(WORD_W)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_i,
  input logic                  led_o,
  input blink_state_e          state_i,
  input logic [WORD_W-1:0]     word_i,
  input logic [IDX_W-1:0]      bit_idx_i,
  input logic [UNIT_CNT_W-1:0] units_i,
  input logic                  sub_tick_i,
  input logic                  unit_tick_i
);
  // R1: idle keeps the LED dark
  a_r1_idle_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> (led_o == ACTIVE_LOW));

  // R7: shown word cannot change during display
  a_r7_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> $stable(word_i));

  // R3: state advances only on a unit tick or a load accepted from idle
  a_r3_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_tick_i && !(load_i && state_i == ST_IDLE)) |=> $stable(state_i));

  // R3: next bit is one lower
  a_r3_bit_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_GAP && $past(state_i) == ST_MARK) |-> (bit_idx_i == $past(bit_idx_i) - 1'b1));

  // R4: unit count in range while active
  a_r4_units_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |-> (units_i >= 1 && units_i <= PAUSE_UNITS));

  // R5: unit tick implies a sub-tick
  a_r5_unit_on_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_tick_i |-> sub_tick_i);

  // R8: lit state shows the active level next cycle
  a_r8_mark_lit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_MARK) |=> (led_o == !ACTIVE_LOW));
endmodule

bind blink_word_reporter blink_word_reporter_chk #(.WORD_W(WORD_W), .ACTIVE_LOW(ACTIVE_LOW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .led_o      (led_o),
  .state_i    (seq_state),
  .word_i     (shown_word),
  .bit_idx_i  (bit_idx),
  .units_i    (units_left),
  .sub_tick_i (sub_tick),
  .unit_tick_i(unit_tick)
);

// File: tb/blink_word_reporter_tb_top.sv
module blink_word_reporter_tb_top;
  localparam int DIV_W = 4;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load = 1'b0;
  logic [31:0]      word = '0;
  logic [DIV_W-1:0] sub_div = 4'd1;
  logic [LEN_W-1:0] unit_len = 4'd1;
  logic             led_hi, led_lo;
  int               n_checks = 0;
  int               n_fail = 0;

  always #2 clk = ~clk;

  blink_word_reporter #(.DIV_W(DIV_W), .LEN_W(LEN_W), .ACTIVE_LOW(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .word_i(word),
    .sub_div_i(sub_div), .unit_len_i(unit_len), .led_o(led_hi));

  blink_word_reporter #(.DIV_W(DIV_W), .LEN_W(LEN_W), .ACTIVE_LOW(1'b1)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .word_i(word),
    .sub_div_i(sub_div), .unit_len_i(unit_len), .led_o(led_lo));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [31:0] w, input int u);
    int f = 10 * u;
    for (int i = 0; i < 32; i++) f += u + (w[i] ? 3 * u : u);
    return f;
  endfunction

  function automatic bit lit_at(input logic [31:0] w, input int u, input int t);
    int tt = t % frame_len(w, u);
    for (int i = 31; i >= 0; i--) begin
      int m = w[i] ? 3 * u : u;
      if (tt < u) return 1'b0;
      tt -= u;
      if (tt < m) return 1'b1;
      tt -= m;
    end
    return 1'b0;
  endfunction

  task automatic do_load(input logic [31:0] w, input int d, input int l);
    @(negedge clk);
    sub_div = DIV_W'(d);
    unit_len = LEN_W'(l);
    word = w;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // compares nfr frames; at cycle poke drives a foreign load and new timing
  task automatic run_frames(input logic [31:0] w, input int u, input int nfr,
                            input int poke, input string req);
    int total = frame_len(w, u) * nfr;
    int bad = 0, bad_lo = 0, first = -1;
    bit gval = 1'b0, eval = 1'b0;
    for (int t = 0; t < total; t++) begin
      bit e;
      @(negedge clk);
      e = lit_at(w, u, t);
      if (led_hi !== e) begin
        bad++;
        if (first < 0) begin first = t; gval = led_hi; eval = e; end
      end
      if (led_lo !== !e) bad_lo++;
      if (t == poke) begin
        load = 1'b1;
        word = ~w;
        sub_div = sub_div + 1'b1;
        unit_len = unit_len + 1'b1;
      end else begin
        load = 1'b0;
      end
    end
    check(bad == 0, req, $sformatf("waveform w=%h u=%0d first bad cycle %0d", w, u, first),
          longint'(gval), longint'(eval));
    check(bad_lo == 0, "R8", $sformatf("inverted waveform w=%h mismatches", w),
          longint'(bad_lo), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int errs;
    // reset levels
    repeat (3) @(negedge clk);
    check(led_hi == 1'b0, "R1", "dark in reset (active high)", led_hi, 0);
    check(led_lo == 1'b1, "R8", "dark in reset (active low)", led_lo, 1);
    rst_n = 1'b1;
    errs = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      word = 32'hFFFF_0000 ^ 32'(t);
      sub_div = DIV_W'(t);
      if (led_hi !== 1'b0 || led_lo !== 1'b1) errs++;
    end
    check(errs == 0, "R1", "idle cycles not dark", errs, 0);

    // R2 R3 R4: several words, two frames each
    do_load(32'h8000_0001, 2, 3);
    run_frames(32'h8000_0001, 6, 2, -1, "R3");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'h0000_0000, 2, 2);
    run_frames(32'h0000_0000, 4, 2, -1, "R4");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'hFFFF_FFFF, 1, 2);
    run_frames(32'hFFFF_FFFF, 2, 2, -1, "R2");

    // R5: sweep divider and sub-tick count
    for (int d = 1; d <= 3; d++) begin
      for (int l = 1; l <= 3; l++) begin
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        do_load(32'hA5C3_0F96, d, l);
        run_frames(32'hA5C3_0F96, d * l, 1, -1, "R5");
      end
    end
    // R5: zero settings count as one
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'h0000_FFFF, 0, 0);
    run_frames(32'h0000_FFFF, 1, 2, -1, "R5");

    // R6 R7: foreign load and new timing mid display
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'h1234_5678, 2, 2);
    run_frames(32'h1234_5678, 4, 2, 37, "R7");
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'hC001_D00D, 3, 1);
    run_frames(32'hC001_D00D, 3, 1, 0, "R6");

    // R9: reset during a lit pulse
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    do_load(32'hFFFF_FFFF, 2, 2);
    repeat (6) @(negedge clk);
    check(led_hi == 1'b1, "R9", "lit before reset", led_hi, 1);
    rst_n = 1'b0;
    #1;
    check(led_hi == 1'b0, "R9", "dark at once on reset", led_hi, 0);
    check(led_lo == 1'b1, "R9", "dark at once on reset (active low)", led_lo, 1);
    @(negedge clk);
    rst_n = 1'b1;
    do_load(32'h0F0F_0F0F, 1, 3);
    run_frames(32'h0F0F_0F0F, 3, 1, -1, "R9");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule